// File: doc/BRIEF.md
# Low-Frequency Timer and Watchdog Unit

This block runs from a slow clock (nominally 32.768 kHz) and splits it into three tick rates with one shared binary divider. The ticks drive three timers: a time-of-day counter made of an 8-bit count-down fraction stage that carries into a 32-bit seconds register, an interval timer with a 16-bit reload modulus and a sticky interrupt flag, and a 6-bit watchdog. The watchdog asserts the chip reset output unless software writes a fixed two-word service pattern before it counts out.

Software reaches enables, reload values, counts and status through a small register bus with a one-cycle read latency. Until an oscillator-stable input has been seen high through a two-stage synchronizer, the divider is held at zero, no tick is issued and the chip reset output stays asserted.

Top module: `lft_unit`

## Requirements
- R1: The divider issues an interval tick every 2^PIT_SHIFT cycles, a time-of-day tick every 2^TOD_SHIFT cycles and a watchdog tick every 2^WDT_SHIFT cycles (defaults 4, 128 and 16384, giving 8 kHz, 256 Hz and 2 Hz from 32.768 kHz).
- R2: With bit 0 of the control register (address 0) set, the fraction register (address 4, bits 7:0) decrements on each time-of-day tick; on a tick that finds it at zero it reloads 8'hFF and the seconds register (address 5) increments by one on that same tick.
- R3: The seconds register advances exactly once per 256 time-of-day ticks.
- R4: With control bit 1 set, the interval count starts from the modulus M (address 2, bits 15:0) and counts down one per interval tick; a tick at zero reloads M and sets the flag (status register address 1, bit 0), so the flag is set every M+1 ticks.
- R5: Writing 1 to status bit 0 clears the flag (a set in the same cycle wins); output pit_irq_o equals flag AND control bit 2, one cycle later.
- R6: Setting control bit 3 loads the watchdog count (address 8) from its 6-bit reload value (address 6); each watchdog tick decrements it, and when it is zero chip_rst_o rises two cycles later and stays high until rst.
- R7: Writing 16'h5555 then 16'hAAAA (bits 15:0) to the service register (address 7) reloads the watchdog count; any other write between the two, to any address, cancels the pattern.
- R8: Once control bit 3 is set, writing it 0 has no effect until rst.
- R9: While the synchronized oscillator-stable input is low, chip_rst_o is high and no timer advances.
- R10: After rst the control reads 0, fraction 8'hFF, seconds 0, modulus 16'hFFFF, watchdog reload 6'h3F; read data appears on bus_rdata one cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timer clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_stable_i | input | 1 | Oscillator settled indication (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pit_irq_o | output | 1 | Interval timer interrupt, registered |
| chip_rst_o | output | 1 | Chip reset request, registered |

## Verification
Register reads are due one cycle after the strobe, pit_irq_o one cycle after the flag, and chip_rst_o two cycles after the watchdog count is zero or three cycles after the stable input drops. Because the divider phase relative to a bus write is not fixed, the bench measures intervals between two events of the same kind, such as successive interrupt rises or a seconds carry and the next one, which are exact multiples of the tick period. Where a single event is timed from a write, as for the watchdog bite, the check allows the one-tick phase window and no more.

// File: rtl/lft_pkg.sv
package lft_pkg;
  localparam int AW = 4;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_STAT  = 4'd1;
  localparam logic [AW-1:0] A_PMOD  = 4'd2;
  localparam logic [AW-1:0] A_PCNT  = 4'd3;
  localparam logic [AW-1:0] A_FRAC  = 4'd4;
  localparam logic [AW-1:0] A_SEC   = 4'd5;
  localparam logic [AW-1:0] A_WLOAD = 4'd6;
  localparam logic [AW-1:0] A_WSVC  = 4'd7;
  localparam logic [AW-1:0] A_WCNT  = 4'd8;

  localparam logic [15:0] SVC_FIRST  = 16'h5555;
  localparam logic [15:0] SVC_SECOND = 16'hAAAA;

  typedef struct packed {
    logic wdt_en;
    logic irq_en;
    logic pit_en;
    logic tod_en;
  } ctrl_t;
endpackage

// File: rtl/lft_prescale.sv
module lft_prescale #(
  parameter int PIT_SHIFT = 2,
  parameter int TOD_SHIFT = 7,
  parameter int WDT_SHIFT = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick_pit,
  output logic tick_tod,
  output logic tick_wdt
);
  localparam int W = WDT_SHIFT;
  localparam int SH [3] = '{PIT_SHIFT, TOD_SHIFT, WDT_SHIFT};

  logic [W-1:0] div_q;
  logic [2:0]   tick_q;

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  for (genvar i = 0; i < 3; i++) begin : g_tap
    localparam logic [W-1:0] MASK = W'((64'd1 << SH[i]) - 64'd1);
    logic t_q;
    always_ff @(posedge clk) begin
      if (rst || !run) t_q <= 1'b0;
      else             t_q <= ((div_q & MASK) == MASK);
    end
    assign tick_q[i] = t_q;
  end

  assign tick_pit = tick_q[0];
  assign tick_tod = tick_q[1];
  assign tick_wdt = tick_q[2];
endmodule

// File: rtl/lft_tod.sv
module lft_tod #(
  parameter int FW = 8,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          wr_frac,
  input  logic          wr_sec,
  input  logic [SW-1:0] wdata,
  output logic [FW-1:0] frac,
  output logic [SW-1:0] sec
);
  logic step, carry;
  assign step  = tick && en;
  assign carry = step && (frac == '0);

  always_ff @(posedge clk) begin
    if (rst)          frac <= '1;
    else if (wr_frac) frac <= wdata[FW-1:0];
    else if (carry)   frac <= '1;
    else if (step)    frac <= frac - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         sec <= '0;
    else if (wr_sec) sec <= wdata;
    else if (carry)  sec <= sec + 1'b1;
  end
endmodule

// File: rtl/lft_pit.sv
module lft_pit #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic [MW-1:0] modulus,
  input  logic          clr_flag,
  output logic [MW-1:0] cnt,
  output logic          flag
);
  logic term;
  assign term = tick && en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '1;
    else if (!en || term)   cnt <= modulus;
    else if (tick)          cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (term)     flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end
endmodule

// File: rtl/lft_wdt.sv
module lft_wdt
  import lft_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en_set,
  input  logic          wr_load,
  input  logic          wr_svc,
  input  logic          wr_other,
  input  logic [15:0]   wdata,
  output logic          en,
  output logic [CW-1:0] load,
  output logic [CW-1:0] cnt,
  output logic          bite
);
  logic armed, seq_done, start, reload;

  assign seq_done = wr_svc && armed && (wdata == SVC_SECOND);
  assign start    = en_set && !en;
  assign reload   = start || (en && seq_done);

  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (wr_svc) armed <= (wdata == SVC_FIRST);
    else if (wr_other) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         en <= 1'b0;
    else if (en_set) en <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          load <= '1;
    else if (wr_load) load <= wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '1;
    else if (reload)                  cnt <= load;
    else if (en && tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bite <= 1'b0;
    else     bite <= bite || (en && cnt == '0);
  end
endmodule

// File: rtl/lft_unit.sv
module lft_unit
  import lft_pkg::*;
#(
  parameter int PIT_SHIFT = 2,
  parameter int TOD_SHIFT = 7,
  parameter int WDT_SHIFT = 14,
  parameter int PMW       = 16,
  parameter int WCW       = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_stable_i,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pit_irq_o,
  output logic          chip_rst_o
);
  localparam int FW = 8;

  logic sync1_q, stable_q;
  ctrl_t ctrl_q;
  logic [PMW-1:0] pmod_q, pit_cnt;
  logic pit_flag;
  logic [FW-1:0] frac;
  logic [DW-1:0] sec;
  logic wdt_en, wdt_bite;
  logic [WCW-1:0] wdt_load, wdt_cnt;
  logic tick_pit, tick_tod, tick_wdt;

  logic wr_ctrl, wr_stat, wr_pmod, wr_frac, wr_sec, wr_wload, wr_wsvc;
  assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  assign wr_stat  = bus_wr && bus_addr == A_STAT;
  assign wr_pmod  = bus_wr && bus_addr == A_PMOD;
  assign wr_frac  = bus_wr && bus_addr == A_FRAC;
  assign wr_sec   = bus_wr && bus_addr == A_SEC;
  assign wr_wload = bus_wr && bus_addr == A_WLOAD;
  assign wr_wsvc  = bus_wr && bus_addr == A_WSVC;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q  <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      sync1_q  <= osc_stable_i;
      stable_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.tod_en <= 1'b0;
      ctrl_q.pit_en <= 1'b0;
      ctrl_q.irq_en <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q.tod_en <= bus_wdata[0];
      ctrl_q.pit_en <= bus_wdata[1];
      ctrl_q.irq_en <= bus_wdata[2];
    end
  end
  assign ctrl_q.wdt_en = wdt_en;

  always_ff @(posedge clk) begin
    if (rst)          pmod_q <= '1;
    else if (wr_pmod) pmod_q <= bus_wdata[PMW-1:0];
  end

  lft_prescale #(
    .PIT_SHIFT(PIT_SHIFT), .TOD_SHIFT(TOD_SHIFT), .WDT_SHIFT(WDT_SHIFT)
  ) u_pre (
    .clk(clk), .rst(rst), .run(stable_q),
    .tick_pit(tick_pit), .tick_tod(tick_tod), .tick_wdt(tick_wdt)
  );

  lft_tod #(.FW(FW), .SW(DW)) u_tod (
    .clk(clk), .rst(rst), .tick(tick_tod), .en(ctrl_q.tod_en),
    .wr_frac(wr_frac), .wr_sec(wr_sec), .wdata(bus_wdata),
    .frac(frac), .sec(sec)
  );

  lft_pit #(.MW(PMW)) u_pit (
    .clk(clk), .rst(rst), .tick(tick_pit), .en(ctrl_q.pit_en),
    .modulus(pmod_q), .clr_flag(wr_stat && bus_wdata[0]),
    .cnt(pit_cnt), .flag(pit_flag)
  );

  lft_wdt #(.CW(WCW)) u_wdt (
    .clk(clk), .rst(rst), .tick(tick_wdt),
    .en_set(wr_ctrl && bus_wdata[3]), .wr_load(wr_wload),
    .wr_svc(wr_wsvc), .wr_other(bus_wr && !wr_wsvc),
    .wdata(bus_wdata[15:0]),
    .en(wdt_en), .load(wdt_load), .cnt(wdt_cnt), .bite(wdt_bite)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pit_irq_o  <= 1'b0;
      chip_rst_o <= 1'b1;
    end else begin
      pit_irq_o  <= pit_flag && ctrl_q.irq_en;
      chip_rst_o <= !stable_q || wdt_bite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata <= DW'(ctrl_q);
        A_STAT:  bus_rdata <= DW'(pit_flag);
        A_PMOD:  bus_rdata <= DW'(pmod_q);
        A_PCNT:  bus_rdata <= DW'(pit_cnt);
        A_FRAC:  bus_rdata <= DW'(frac);
        A_SEC:   bus_rdata <= sec;
        A_WLOAD: bus_rdata <= DW'(wdt_load);
        A_WCNT:  bus_rdata <= DW'(wdt_cnt);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lft_chk.sv
module lft_chk #(
  parameter int WCW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           osc_stable_i,
  input logic           chip_rst_o,
  input logic           stable_q,
  input logic           tick_pit,
  input logic           tick_tod,
  input logic           tick_wdt,
  input logic           tod_en,
  input logic           wr_frac,
  input logic           wr_sec,
  input logic [7:0]     frac,
  input logic [31:0]    sec,
  input logic           pit_flag,
  input logic           pit_clr,
  input logic           wdt_en,
  input logic [WCW-1:0] wdt_cnt
);
  // R9
  osc_low_rst_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_stable_i |-> ##3 chip_rst_o);

  // R9
  no_tick_unstable_chk: assert property (@(posedge clk) disable iff (rst)
    !stable_q |=> !(tick_pit || tick_tod || tick_wdt));

  // R2
  tod_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_tod && tod_en && frac == 8'h00 && !wr_frac && !wr_sec)
      |=> (frac == 8'hFF && sec == $past(sec) + 32'd1));

  // R5
  pit_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pit_flag && !pit_clr) |=> pit_flag);

  // R8
  wdt_en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_en |=> wdt_en);

  // R6
  wdt_bite_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_en && wdt_cnt == '0) |-> ##2 chip_rst_o);
endmodule

bind lft_unit lft_chk #(.WCW(WCW)) u_chk (
  .clk(clk), .rst(rst), .osc_stable_i(osc_stable_i), .chip_rst_o(chip_rst_o),
  .stable_q(stable_q), .tick_pit(tick_pit), .tick_tod(tick_tod),
  .tick_wdt(tick_wdt), .tod_en(ctrl_q.tod_en), .wr_frac(wr_frac),
  .wr_sec(wr_sec), .frac(frac), .sec(sec), .pit_flag(pit_flag),
  .pit_clr(wr_stat && bus_wdata[0]), .wdt_en(wdt_en), .wdt_cnt(wdt_cnt)
);

// File: tb/tb_lft_unit.sv
module tb_lft_unit;
  localparam int PS = 1, TS = 3, WS = 6;
  localparam int PDIV = 1 << PS, TDIV = 1 << TS, WDIV = 1 << WS;

  logic clk = 0, rst = 1, osc = 0, bwr = 0, brd = 0;
  logic [3:0] baddr = 0;
  logic [31:0] bwdata = 0, brdata;
  logic irq, crst;
  int cyc = 0, checks = 0, fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lft_unit #(.PIT_SHIFT(PS), .TOD_SHIFT(TS), .WDT_SHIFT(WS)) dut (
    .clk(clk), .rst(rst), .osc_stable_i(osc), .bus_wr(bwr), .bus_rd(brd),
    .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(brdata),
    .pit_irq_o(irq), .chip_rst_o(crst));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset(input logic stable);
    @(negedge clk); rst = 1; osc = stable; bwr = 0; brd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bwr = 1; baddr = a; bwdata = d;
    @(negedge clk); bwr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    brd = 1; baddr = a;
    @(negedge clk); brd = 0; d = brdata;
  endtask

  task automatic t_reset_values;
    logic [31:0] d;
    do_reset(1);
    rd(4'd0, d); check("R10 ctrl", d, 0);
    rd(4'd4, d); check("R10 frac", d, 32'hFF);
    rd(4'd5, d); check("R10 sec", d, 0);
    rd(4'd2, d); check("R10 modulus", d, 32'hFFFF);
    rd(4'd6, d); check("R10 wdt reload", d, 32'h3F);
    check("R10 chip_rst low once stable", crst, 0);
  endtask

  task automatic t_unstable;
    logic [31:0] d;
    do_reset(0);
    check("R9 chip_rst while unstable", crst, 1);
    wr(4'd4, 32'd5); wr(4'd0, 32'h3);
    repeat (200) @(negedge clk);
    rd(4'd4, d); check("R9 frac frozen", d, 5);
    check("R9 no irq", irq, 0);
    osc = 1;
    repeat (6) @(negedge clk);
    check("R9 chip_rst released", crst, 0);
    repeat (3 * TDIV) @(negedge clk);
    rd(4'd4, d); check_rng("R9 frac moves after stable", int'(d), 0, 4);
  endtask

  task automatic t_tod;
    logic [31:0] d;
    int t0;
    do_reset(1);
    wr(4'd5, 32'd41); wr(4'd4, 32'd3); wr(4'd0, 32'h1);
    d = 41;
    while (d == 41) rd(4'd5, d);
    t0 = cyc;
    check("R2 seconds incremented", d, 42);
    rd(4'd4, d); check("R2 fraction reloaded FF", d, 32'hFF);
    while (cyc < t0 + 256 * TDIV - 20) @(negedge clk);
    rd(4'd5, d); check("R3 no early second", d, 42);
    while (cyc < t0 + 256 * TDIV + 10) @(negedge clk);
    rd(4'd5, d); check("R3 R1 next second after 256 ticks", d, 43);
  endtask

  task automatic t_pit;
    int t0;
    logic [31:0] d;
    do_reset(1);
    wr(4'd2, 32'd9); wr(4'd0, 32'h6);
    while (!irq) @(negedge clk);
    t0 = cyc;
    wr(4'd1, 32'h1);
    while (irq) @(negedge clk);
    while (!irq) @(negedge clk);
    check("R4 R1 interrupt period (M+1) ticks", cyc - t0, 10 * PDIV);
    wr(4'd2, 32'd3); wr(4'd0, 32'h2);
    wr(4'd1, 32'h1);
    repeat (40) @(negedge clk);
    check("R5 irq masked", irq, 0);
    rd(4'd1, d); check("R5 flag still set when masked", d, 1);
    wr(4'd0, 32'h0); wr(4'd1, 32'h1);
    rd(4'd1, d); check("R5 write-one clears flag", d, 0);
  endtask

  task automatic t_wdt_service;
    logic [31:0] d;
    do_reset(1);
    wr(4'd6, 32'd4); wr(4'd0, 32'h8);
    for (int i = 0; i < 20; i++) begin
      repeat (100) @(negedge clk);
      wr(4'd7, 32'h5555); wr(4'd7, 32'hAAAA);
    end
    check("R7 serviced watchdog holds off reset", crst, 0);
    wr(4'd0, 32'h0);
    rd(4'd0, d); check("R8 wdt enable stays set", d[3], 1);
  endtask

  task automatic t_wdt_badseq;
    logic [31:0] d;
    do_reset(1);
    wr(4'd6, 32'd20); wr(4'd0, 32'h8);
    repeat (600) @(negedge clk);
    wr(4'd7, 32'h5555); wr(4'd2, 32'h10); wr(4'd7, 32'hAAAA);
    rd(4'd8, d); check_rng("R7 other write cancels pattern", int'(d), 8, 12);
    wr(4'd7, 32'h5555); wr(4'd7, 32'h1234); wr(4'd7, 32'hAAAA);
    rd(4'd8, d); check_rng("R7 wrong word cancels pattern", int'(d), 8, 12);
    wr(4'd7, 32'h5555); wr(4'd7, 32'hAAAA);
    rd(4'd8, d); check_rng("R7 good pattern reloads", int'(d), 19, 20);
  endtask

  task automatic t_wdt_bite;
    int t0;
    do_reset(1);
    wr(4'd6, 32'd4); wr(4'd0, 32'h8);
    t0 = cyc;
    while (!crst && cyc < t0 + 10 * WDIV) @(negedge clk);
    check_rng("R6 bite time", cyc - t0, 3 * WDIV, 4 * WDIV + 4);
    repeat (200) @(negedge clk);
    check("R6 reset output sticky", crst, 1);
  endtask

  initial begin
    fork
      begin
        t_reset_values();
        t_unstable();
        t_tod();
        t_pit();
        t_wdt_service();
        t_wdt_badseq();
        t_wdt_bite();
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule